// File: doc/BRIEF.md
# Optical-Drive PIO Read Byte-Count Sequencer

This block paces host programmed-I/O reads of optical-drive data out of a 2048-byte staging buffer. A transfer is opened with a start pulse that carries the total byte length and the host's requested byte count per increment. Each host read moves the transfer index forward by the access length, returns the buffer offset to read from, and, whenever the index crosses a 2048-byte boundary, holds the read until an external media model has refilled the buffer.

The host sees the transfer cut into increments. At the close of each increment the block pulses the interrupt (unless masked), marks the data as flowing to the host, and either reloads the cylinder byte-count register with the bytes still owed or, at the end, drops data-request and flags command completion. Identify-type transfers run in a plain mode with no refills, no increments and no interrupts; data-request simply falls when the index reaches the length.

The controller has four states. `S_IDLE` holds after reset. `S_XFER` waits for host reads; a start pulse enters it from any state. A read at a 2048-byte edge moves `S_XFER` to `S_REFILL`, which returns to `S_XFER` on refill-done, or to `S_DONE` when that read ends the transfer. A read that ends the transfer moves `S_XFER` to `S_DONE`. In `S_IDLE` and `S_DONE` every read is an overrun.

Top module: `atapi_pio_rd_seq`

## Requirements
- R1: After reset, data-request, ready, busy, the three reason flags, the byte count and the transfer index are all 0, and no acknowledge, error, refill or interrupt is asserted.
- R2: A start pulse clears the index, sets data-request to 1, ready and busy to 0, all reason flags to 0, and loads the byte count with the requested increment length; a read presented in the same cycle is dropped.
- R3: An accepted read gives a one-cycle acknowledge on the next edge, with the offset equal to the index before the read modulo 2048, and the index advances by the access length (1 to 4).
- R4: A read while the index is at or beyond the total length, or while no transfer is open, gives a one-cycle error pulse, no acknowledge, and leaves the index unchanged.
- R5: A non-identify read with nonzero index whose offset is 0 raises refill-request and busy from the next cycle; no acknowledge occurs and further reads are ignored until refill-done is sampled, after which the held read is acknowledged on the next edge, busy clears and refill-request drops.
- R6: An increment boundary occurs on a read after which the bytes read since the last boundary reach the request length, or after which the index reaches the total length.
- R7: At a boundary with data left, data-request stays 1, command/data is 0, and the byte count becomes total minus the new index.
- R8: At the boundary that ends the transfer, data-request goes to 0, ready to 1, command/data to 1 and release to 0; the byte count is left unchanged.
- R9: At every boundary the I/O-direction flag becomes 1, busy is 0, and a one-cycle interrupt pulse is given unless the interrupt-disable input is high.
- R10: The reason flags appear in the sector-count position: bit 0 command/data, bit 1 I/O direction, bit 2 release.
- R11: In identify mode reads never request a refill or an interrupt, leave the reason flags and byte count as loaded, set ready, and clear data-request when the index reaches the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new transfer |
| id_mode | input | 1 | Transfer is identify-type (sampled at start) |
| total_len | input | 16 | Total transfer bytes (sampled at start) |
| req_len | input | 16 | Bytes per increment, nonzero (sampled at start) |
| irq_dis | input | 1 | Masks the interrupt pulse |
| rd_req | input | 1 | Host read request |
| rd_len | input | 3 | Access length in bytes, 1 to 4 |
| refill_done | input | 1 | Media model has refilled the buffer |
| rd_ack | output | 1 | Read accepted, offset valid |
| rd_off | output | 11 | Buffer offset of the accepted read |
| rd_err | output | 1 | Overrun pulse |
| refill_req | output | 1 | Buffer refill wanted, read held |
| irq | output | 1 | Interrupt pulse |
| drq | output | 1 | Data-request status |
| drdy | output | 1 | Ready status |
| bsy | output | 1 | Busy status |
| ireason | output | 3 | Reason flags {release, I/O, command/data} |
| byte_count | output | 16 | Cylinder low/high byte count |
| xfer_index | output | 17 | Bytes transferred so far |

## Verification
The hardest situation to reach is the refill stall, which only occurs after 2048 bytes have been read in one transfer while no increment boundary falls exactly on that edge. The stimulus opens a transfer of 2052 bytes with a request length of 4096 and issues 512 four-byte reads, so the 513th read lands on the buffer edge with no interrupt yet pending; a second read is then presented during the stall to show it is ignored, and releasing refill-done ends the transfer at the final boundary in the same read.

// File: rtl/atapi_rd_pkg.sv
package atapi_rd_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_XFER   = 2'd1,
        S_REFILL = 2'd2,
        S_DONE   = 2'd3
    } seq_state_e;

    // bit positions of the reason flags inside the sector-count byte
    localparam int RSN_COD = 0;
    localparam int RSN_IO  = 1;
    localparam int RSN_REL = 2;
    localparam int RSN_W   = 3;

endpackage

// File: rtl/atapi_rd_index.sv
module atapi_rd_index #(
    parameter int LEN_W     = 16,
    parameter int REQ_W     = 16,
    parameter int ACC_W     = 3,
    parameter int BUF_BYTES = 2048,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int IDX_W    = LEN_W + 1,
    localparam int CNT_W    = REQ_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             id_mode,
    input  logic [LEN_W-1:0] total_len,
    input  logic [REQ_W-1:0] req_len,
    input  logic             fire,
    input  logic [ACC_W-1:0] fire_len,
    output logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off_q,
    output logic             id_q,
    output logic             overrun,
    output logic             at_edge,
    output logic             last,
    output logic             boundary,
    output logic [REQ_W-1:0] remain
);

    logic [LEN_W-1:0] total_q;
    logic [REQ_W-1:0] req_q;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx_next;
    logic [CNT_W-1:0] cnt_next;
    logic [LEN_W-1:0] left;

    always_comb begin
        idx_next = idx + {{(IDX_W-ACC_W){1'b0}}, fire_len};
        cnt_next = cnt + {{(CNT_W-ACC_W){1'b0}}, fire_len};
        last     = idx_next >= {1'b0, total_q};
        boundary = (cnt_next >= {1'b0, req_q}) || last;
        left     = total_q - idx_next[LEN_W-1:0];
        remain   = REQ_W'(left);
        overrun  = idx >= {1'b0, total_q};
        at_edge  = (idx[OFF_W-1:0] == '0) && (idx != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            cnt     <= '0;
            off_q   <= '0;
            total_q <= '0;
            req_q   <= '0;
            id_q    <= 1'b0;
        end else if (start) begin
            idx     <= '0;
            cnt     <= '0;
            total_q <= total_len;
            req_q   <= req_len;
            id_q    <= id_mode;
        end else if (fire) begin
            idx   <= idx_next;
            off_q <= idx[OFF_W-1:0];
            cnt   <= boundary ? '0 : cnt_next;
        end
    end

    // R3: the index moves by exactly the access length of the accepted read
    p_index_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !start) |=> idx == $past(idx) + {{(IDX_W-ACC_W){1'b0}}, $past(fire_len)});

endmodule

// File: rtl/atapi_rd_ctl.sv
module atapi_rd_ctl
    import atapi_rd_pkg::*;
#(
    parameter int ACC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_req,
    input  logic [ACC_W-1:0] rd_len,
    input  logic             refill_done,
    input  logic             overrun,
    input  logic             at_edge,
    input  logic             id_q,
    input  logic             last,
    output logic             fire,
    output logic [ACC_W-1:0] fire_len,
    output logic             park,
    output logic             refill_req,
    output logic             rd_ack,
    output logic             rd_err
);

    seq_state_e       state_q, state_d;
    logic [ACC_W-1:0] len_q;
    logic             err_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        fire_len = rd_len;
        park     = 1'b0;
        err_d    = 1'b0;
        if (start) begin
            state_d = S_XFER;
        end else begin
            unique case (state_q)
                S_IDLE, S_DONE: begin
                    if (rd_req) err_d = 1'b1;
                end
                S_XFER: begin
                    if (rd_req) begin
                        if (overrun) begin
                            err_d = 1'b1;
                        end else if (at_edge && !id_q) begin
                            park    = 1'b1;
                            state_d = S_REFILL;
                        end else begin
                            fire = 1'b1;
                            if (last) state_d = S_DONE;
                        end
                    end
                end
                S_REFILL: begin
                    fire_len = len_q;
                    if (refill_done) begin
                        fire    = 1'b1;
                        state_d = last ? S_DONE : S_XFER;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0;
            rd_err <= 1'b0;
            len_q  <= '0;
        end else begin
            rd_ack <= fire;
            rd_err <= err_d;
            if (park) len_q <= rd_len;
        end
    end

    assign refill_req = (state_q == S_REFILL);

    // R4: a read is either accepted or rejected, never both
    p_ack_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && rd_err));

    // R5: no data is returned while the refill is outstanding
    p_refill_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_done && !start) |=> !rd_ack);

endmodule

// File: rtl/atapi_rd_status.sv
module atapi_rd_status
    import atapi_rd_pkg::*;
#(
    parameter int REQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REQ_W-1:0]  req_len,
    input  logic              irq_dis,
    input  logic              fire,
    input  logic              park,
    input  logic              boundary,
    input  logic              last,
    input  logic              id_q,
    input  logic [REQ_W-1:0]  remain,
    output logic              irq,
    output logic              drq,
    output logic              drdy,
    output logic              bsy,
    output logic [RSN_W-1:0]  ireason,
    output logic [REQ_W-1:0]  byte_count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            drq        <= 1'b0;
            drdy       <= 1'b0;
            bsy        <= 1'b0;
            ireason    <= '0;
            byte_count <= '0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                drq        <= 1'b1;
                drdy       <= 1'b0;
                bsy        <= 1'b0;
                ireason    <= '0;
                byte_count <= req_len;
            end else begin
                if (park) bsy <= 1'b1;
                if (fire) begin
                    bsy <= 1'b0;
                    if (id_q) begin
                        drdy <= 1'b1;
                        if (last) drq <= 1'b0;
                    end else if (boundary) begin
                        ireason[RSN_IO] <= 1'b1;
                        irq             <= !irq_dis;
                        if (last) begin
                            drq              <= 1'b0;
                            drdy             <= 1'b1;
                            ireason[RSN_COD] <= 1'b1;
                            ireason[RSN_REL] <= 1'b0;
                        end else begin
                            drq              <= 1'b1;
                            ireason[RSN_COD] <= 1'b0;
                            byte_count       <= remain;
                        end
                    end
                end
            end
        end
    end

    // R9: an interrupt always comes with data flowing to the host and busy low
    p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ireason[RSN_IO] && !bsy));

    // R8: the closing interrupt reports command completion
    p_final_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !drq) |-> (ireason[RSN_COD] && drdy && !ireason[RSN_REL]));

    // R11: identify transfers never interrupt
    p_id_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        id_q |-> !irq);

endmodule

// File: rtl/atapi_pio_rd_seq.sv
module atapi_pio_rd_seq
    import atapi_rd_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int REQ_W     = 16,
    parameter int ACC_W     = 3,
    parameter int BUF_BYTES = 2048,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int IDX_W    = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             id_mode,
    input  logic [LEN_W-1:0] total_len,
    input  logic [REQ_W-1:0] req_len,
    input  logic             irq_dis,
    input  logic             rd_req,
    input  logic [ACC_W-1:0] rd_len,
    input  logic             refill_done,
    output logic             rd_ack,
    output logic [OFF_W-1:0] rd_off,
    output logic             rd_err,
    output logic             refill_req,
    output logic             irq,
    output logic             drq,
    output logic             drdy,
    output logic             bsy,
    output logic [RSN_W-1:0] ireason,
    output logic [REQ_W-1:0] byte_count,
    output logic [IDX_W-1:0] xfer_index
);

    logic             fire, park, id_q, overrun, at_edge, last, boundary;
    logic [ACC_W-1:0] fire_len;
    logic [REQ_W-1:0] remain;

    atapi_rd_index #(
        .LEN_W(LEN_W), .REQ_W(REQ_W), .ACC_W(ACC_W), .BUF_BYTES(BUF_BYTES)
    ) index_i (
        .clk(clk), .rst_n(rst_n), .start(start), .id_mode(id_mode),
        .total_len(total_len), .req_len(req_len),
        .fire(fire), .fire_len(fire_len),
        .idx(xfer_index), .off_q(rd_off), .id_q(id_q),
        .overrun(overrun), .at_edge(at_edge), .last(last),
        .boundary(boundary), .remain(remain)
    );

    atapi_rd_ctl #(.ACC_W(ACC_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .rd_len(rd_len), .refill_done(refill_done), .overrun(overrun),
        .at_edge(at_edge), .id_q(id_q), .last(last),
        .fire(fire), .fire_len(fire_len), .park(park),
        .refill_req(refill_req), .rd_ack(rd_ack), .rd_err(rd_err)
    );

    atapi_rd_status #(.REQ_W(REQ_W)) status_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
        .irq_dis(irq_dis), .fire(fire), .park(park), .boundary(boundary),
        .last(last), .id_q(id_q), .remain(remain),
        .irq(irq), .drq(drq), .drdy(drdy), .bsy(bsy),
        .ireason(ireason), .byte_count(byte_count)
    );

endmodule

// File: tb/atapi_pio_rd_seq_tb_top.sv
`timescale 1ns/1ps
module atapi_pio_rd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, start, id_mode, irq_dis, rd_req, refill_done;
    logic [15:0] total_len, req_len;
    logic [2:0]  rd_len;
    logic        rd_ack, rd_err, refill_req, irq, drq, drdy, bsy;
    logic [10:0] rd_off;
    logic [2:0]  ireason;
    logic [15:0] byte_count;
    logic [16:0] xfer_index;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    atapi_pio_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .id_mode(id_mode),
        .total_len(total_len), .req_len(req_len), .irq_dis(irq_dis),
        .rd_req(rd_req), .rd_len(rd_len), .refill_done(refill_done),
        .rd_ack(rd_ack), .rd_off(rd_off), .rd_err(rd_err),
        .refill_req(refill_req), .irq(irq), .drq(drq), .drdy(drdy),
        .bsy(bsy), .ireason(ireason), .byte_count(byte_count),
        .xfer_index(xfer_index)
    );

    // increment table: total 10 bytes, request length 4
    localparam int NV = 5;
    localparam int T_LEN [NV] = '{1, 3, 2, 2, 2};
    localparam int T_OFF [NV] = '{0, 1, 4, 6, 8};
    localparam int T_IDX [NV] = '{1, 4, 6, 8, 10};
    localparam int T_IRQ [NV] = '{0, 1, 0, 1, 1};
    localparam int T_DRQ [NV] = '{1, 1, 1, 1, 0};
    localparam int T_RSN [NV] = '{0, 2, 2, 2, 3};
    localparam int T_BC  [NV] = '{4, 6, 6, 2, 2};

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic rd(input int len);
        @(negedge clk);
        rd_req = 1'b1;
        rd_len = 3'(len);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic open_xfer(input int tot, input int req, input logic idm, input logic dis);
        @(negedge clk);
        start     = 1'b1;
        total_len = 16'(tot);
        req_len   = 16'(req);
        id_mode   = idm;
        irq_dis   = dis;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int bad;
        rst_n = 1'b0; start = 1'b0; id_mode = 1'b0; irq_dis = 1'b0;
        rd_req = 1'b0; rd_len = 3'd0; refill_done = 1'b0;
        total_len = 16'd0; req_len = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 drq", drq, 0);
        chk("R1 drdy", drdy, 0);
        chk("R1 bsy", bsy, 0);
        chk("R1 ireason", ireason, 0);
        chk("R1 byte_count", byte_count, 0);
        chk("R1 index", xfer_index, 0);
        chk("R1 pulses", {rd_ack, rd_err, refill_req, irq}, 0);

        // R4: read with no transfer open
        rd(2);
        chk("R4 idle err", rd_err, 1);
        chk("R4 idle no ack", rd_ack, 0);

        // R2: start loads state
        open_xfer(10, 4, 1'b0, 1'b0);
        chk("R2 drq", drq, 1);
        chk("R2 ireason", ireason, 0);
        chk("R2 byte_count", byte_count, 4);
        chk("R2 index", xfer_index, 0);

        // R3 R6 R7 R8 R9 R10: increment table walk
        for (int i = 0; i < NV; i++) begin
            rd(T_LEN[i]);
            chk($sformatf("R3 ack row%0d", i), rd_ack, 1);
            chk($sformatf("R3 offset row%0d", i), rd_off, T_OFF[i]);
            chk($sformatf("R3 index row%0d", i), xfer_index, T_IDX[i]);
            chk($sformatf("R6 R9 irq row%0d", i), irq, T_IRQ[i]);
            chk($sformatf("R7 R8 drq row%0d", i), drq, T_DRQ[i]);
            chk($sformatf("R10 ireason row%0d", i), ireason, T_RSN[i]);
            chk($sformatf("R7 byte_count row%0d", i), byte_count, T_BC[i]);
            chk($sformatf("R9 bsy row%0d", i), bsy, 0);
        end
        chk("R8 drdy final", drdy, 1);

        // R4: overrun after completion
        rd(2);
        chk("R4 overrun err", rd_err, 1);
        chk("R4 overrun no ack", rd_ack, 0);
        chk("R4 overrun index", xfer_index, 10);

        // R5: refill stall at the 2048-byte edge
        open_xfer(2052, 4096, 1'b0, 1'b0);
        bad = 0;
        for (int i = 0; i < 512; i++) begin
            rd(4);
            if (!rd_ack || irq || refill_req) bad++;
        end
        chk("R5 first 2048 bytes clean", bad, 0);
        chk("R5 index at edge", xfer_index, 2048);
        rd(4);
        chk("R5 refill_req", refill_req, 1);
        chk("R5 held no ack", rd_ack, 0);
        chk("R5 bsy during refill", bsy, 1);
        rd(4);
        chk("R5 second read ignored ack", rd_ack, 0);
        chk("R5 second read ignored index", xfer_index, 2048);
        @(negedge clk);
        refill_done = 1'b1;
        @(negedge clk);
        refill_done = 1'b0;
        chk("R5 ack after refill", rd_ack, 1);
        chk("R5 offset after refill", rd_off, 0);
        chk("R5 index after refill", xfer_index, 2052);
        chk("R5 refill_req dropped", refill_req, 0);
        chk("R5 bsy cleared", bsy, 0);
        chk("R8 final irq after refill", irq, 1);
        chk("R8 drq after refill", drq, 0);

        // R9: masked interrupt, flags still update
        open_xfer(4, 2, 1'b0, 1'b1);
        rd(2);
        chk("R9 masked irq", irq, 0);
        chk("R9 io set while masked", ireason, 2);
        chk("R7 byte_count masked", byte_count, 2);
        rd(2);
        chk("R9 masked final irq", irq, 0);
        chk("R8 masked final drq", drq, 0);

        // R11: identify mode
        open_xfer(4, 2, 1'b1, 1'b0);
        rd(2);
        chk("R11 no irq", irq, 0);
        chk("R11 drq held", drq, 1);
        chk("R11 ireason held", ireason, 0);
        chk("R11 byte_count held", byte_count, 2);
        chk("R11 drdy set", drdy, 1);
        rd(2);
        chk("R11 drq cleared", drq, 0);
        chk("R11 final no irq", irq, 0);
        chk("R11 index", xfer_index, 4);

        // R2: read in the start cycle is dropped
        @(negedge clk);
        start = 1'b1; total_len = 16'd8; req_len = 16'd4; id_mode = 1'b0; irq_dis = 1'b0;
        rd_req = 1'b1; rd_len = 3'd2;
        @(negedge clk);
        start = 1'b0; rd_req = 1'b0;
        chk("R2 same-cycle read dropped", xfer_index, 0);
        chk("R2 same-cycle no ack", rd_ack, 0);

        report();
    end

endmodule